// File: doc/BRIEF.md
# Fixed-Pattern Memory Readback Tester

This block is a self-contained memory integrity probe. A one-cycle start pulse from a sequencer makes it write a fixed set of 64 data words into consecutive word addresses through a simple synchronous request port. It then reads every word back several times in a row and compares each response with the value it wrote. The test ends at the first miscompare, or after the last read of the last word. At the end it raises a one-cycle done pulse and a pass flag.

The pattern is chosen to stress the data lines. Every word is either a base value or its exact bit inverse, so neighbouring accesses swing many bits at once. A group of external error flags is also sampled when the final read completes. A clean compare run with any flag raised still counts as a failure. Only one test runs at a time, and start pulses that arrive during a run are ignored.

Top module: `mem_readback_tester`

## Requirements
- R1: While reset is active and after it is released, `mem_req_o`, `busy_o`, `done_o` and `pass_o` are 0 until a start pulse is accepted.
- R2: A start pulse in idle causes exactly 64 write requests (`mem_req_o`=1, `mem_we_o`=1) on 64 consecutive cycles, beginning the cycle after the pulse, to addresses BASE_ADDR, BASE_ADDR+1, ... BASE_ADDR+63 in ascending order.
- R3: The word written to offset i (0..63) is defined from the group g = i/16 and the position p = i mod 16. The word is the group's second value when p is one of 2, 3, 6, 7, 8, 9, 12 or 13, and the group's first value otherwise. The pairs (first/second) are: g=0: 0x00000000/0xFFFFFFFF; g=1: 0xAAAAAAAA/0x55555555; g=2: 0xA5A5A5A5/0x5A5A5A5A; g=3: 0xAA55AA55/0x55AA55AA.
- R4: After the writes, read requests (`mem_req_o`=1, `mem_we_o`=0) go to offsets in ascending order, 10 consecutive reads per offset. A new read request is issued only after `mem_rvalid_i` has returned the previous one, with any response latency.
- R5: A response whose data differs from the expected word ends the test. No further requests are issued, and `done_o` pulses with `pass_o`=0.
- R6: When all 640 responses match, `pass_o` is 1 only if all six bits of `err_flags_i` are 0 in the cycle the final response is accepted. Flags raised earlier and cleared by then have no effect.
- R7: `done_o` is high for exactly one cycle per test. `pass_o` carries the result from that cycle on and holds it until the next accepted start, which clears it.
- R8: `busy_o` is high from the cycle after an accepted start up to the cycle before `done_o`. A start pulse while `busy_o` is high is ignored and does not restart or extend the test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse |
| err_flags_i | input | 6 | External error flags, sampled at the end of a clean run |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read response data |
| mem_rvalid_i | input | 1 | Read response valid |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle end-of-test pulse |
| pass_o | output | 1 | Result of the last test |

## Verification
A wrong word index or pattern select shows up on `mem_wdata_o` or `mem_addr_o` in the same cycle as the faulty write request. A repeat counter that is off by one changes the number of reads per offset, and this is visible in the total read count at `done_o`. A fault injected at chosen offsets and read numbers in the memory model checks that the test stops exactly at the corrupted response. The read count then pins down whether any request leaked after the miscompare. Error flags are raised both through a whole run and only during its early part, which shows whether they are sampled at the final response.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WRITE   = 2'd1,
        ST_RD_REQ  = 2'd2,
        ST_RD_WAIT = 2'd3
    } mrt_state_e;

    localparam int PATTERN_WORDS = 64;

endpackage

// File: rtl/mrt_pattern_gen.sv
module mrt_pattern_gen #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int BYTES  = DATA_W / 8;
    localparam int HALVES = DATA_W / 16;

    logic [5:0]        pidx;
    logic              invert;
    logic [DATA_W-1:0] base;

    always_comb begin
        pidx   = 6'(idx_i);
        // positions 2,3,6,7 and 8,9,12,13 of each group of 16 take the inverse
        invert = pidx[1] ^ pidx[3];
        case (pidx[5:4])
            2'd0:    base = '0;
            2'd1:    base = {BYTES{8'hAA}};
            2'd2:    base = {BYTES{8'hA5}};
            default: base = {HALVES{16'hAA55}};
        endcase
        word_o = invert ? ~base : base;
    end
endmodule

// File: rtl/mrt_read_cmp.sv
module mrt_read_cmp #(
    parameter int DATA_W = 32,
    parameter int ERR_W  = 6
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [DATA_W-1:0] expect_i,
    input  logic [ERR_W-1:0]  err_flags_i,
    output logic              match_o,
    output logic              clean_o
);
    always_comb begin
        match_o = (rdata_i == expect_i);
        clean_o = ~|err_flags_i;
    end
endmodule

// File: rtl/mrt_seq_ctrl.sv
module mrt_seq_ctrl
    import mrt_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    parameter int NUM_READS = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         rvalid_i,
    input  logic                         match_i,
    input  logic                         clean_i,
    output logic [$clog2(NUM_WORDS)-1:0] idx_o,
    output logic                         req_o,
    output logic                         we_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         pass_o
);
    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam int REP_W = (NUM_READS > 1) ? $clog2(NUM_READS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
    localparam logic [REP_W-1:0] LAST_REP = REP_W'(NUM_READS - 1);

    typedef struct packed {
        mrt_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [REP_W-1:0] rep;
        logic             done;
        logic             pass;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.state = ST_WRITE;
                    s_d.idx   = '0;
                    s_d.rep   = '0;
                    s_d.pass  = 1'b0;
                end
            end
            ST_WRITE: begin
                if (s_q.idx == LAST_IDX) begin
                    s_d.state = ST_RD_REQ;
                    s_d.idx   = '0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            ST_RD_REQ: s_d.state = ST_RD_WAIT;
            default: begin
                if (rvalid_i) begin
                    if (!match_i) begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                        s_d.pass  = 1'b0;
                    end else if (s_q.rep == LAST_REP) begin
                        s_d.rep = '0;
                        if (s_q.idx == LAST_IDX) begin
                            s_d.state = ST_IDLE;
                            s_d.done  = 1'b1;
                            s_d.pass  = clean_i;
                        end else begin
                            s_d.idx   = s_q.idx + 1'b1;
                            s_d.state = ST_RD_REQ;
                        end
                    end else begin
                        s_d.rep   = s_q.rep + 1'b1;
                        s_d.state = ST_RD_REQ;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, idx: '0, rep: '0, done: 1'b0, pass: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign idx_o  = s_q.idx;
    assign req_o  = (s_q.state == ST_WRITE) || (s_q.state == ST_RD_REQ);
    assign we_o   = (s_q.state == ST_WRITE);
    assign busy_o = (s_q.state != ST_IDLE);
    assign done_o = s_q.done;
    assign pass_o = s_q.pass;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_MISMATCH_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_RD_WAIT && rvalid_i && !match_i)
        |=> (!req_o && done_o && !pass_o)); // R5

    AST_WRITE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WRITE && s_q.idx == '0) |-> $past(s_q.state) == ST_IDLE); // R8

    AST_READ_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_RD_REQ && $past(s_q.state) == ST_RD_WAIT)
        |-> (s_q.idx == $past(s_q.idx) || s_q.idx == $past(s_q.idx) + 1'b1)); // R4

endmodule

// File: rtl/mem_readback_tester.sv
module mem_readback_tester #(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 16,
    parameter int                NUM_WORDS = mrt_pkg::PATTERN_WORDS,
    parameter int                NUM_READS = 10,
    parameter int                ERR_W     = 6,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ERR_W-1:0]  err_flags_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] pat_word;
    logic              match;
    logic              clean;

    mrt_pattern_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pat (
        .idx_i  (idx),
        .word_o (pat_word)
    );

    mrt_read_cmp #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_cmp (
        .rdata_i     (mem_rdata_i),
        .expect_i    (pat_word),
        .err_flags_i (err_flags_i),
        .match_o     (match),
        .clean_o     (clean)
    );

    mrt_seq_ctrl #(.NUM_WORDS(NUM_WORDS), .NUM_READS(NUM_READS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .rvalid_i (mem_rvalid_i),
        .match_i  (match),
        .clean_i  (clean),
        .idx_o    (idx),
        .req_o    (mem_req_o),
        .we_o     (mem_we_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .pass_o   (pass_o)
    );

    assign mem_addr_o  = BASE_ADDR + ADDR_W'(idx);
    assign mem_wdata_o = pat_word;

    AST_WRITE_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && $past(mem_req_o && mem_we_o))
        |-> mem_addr_o == $past(mem_addr_o) + 1'b1); // R2

    AST_PASS_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pass_o) |-> $past(err_flags_i) == '0); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o); // R1

endmodule

// File: tb/mem_readback_tester_tb.sv
module mem_readback_tester_tb;
    localparam logic [15:0] BASE = 16'h0100;
    localparam int NV = 8;
    localparam int V_FW  [NV] = '{-1, -1,  0, 63, 17, -1, -1, 40};
    localparam int V_FR  [NV] = '{ 0,  0,  0,  9,  4,  0,  0,  0};
    localparam int V_ERR [NV] = '{ 0,  0,  0,  0,  0,  1, 32,  0};
    localparam int V_LAT [NV] = '{ 0,  2,  0,  1,  0,  0,  1,  3};
    localparam int V_PASS[NV] = '{ 1,  1,  0,  0,  0,  0,  0,  0};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [5:0]  err = '0;
    logic        req, we, busy, done, pass, rvalid;
    logic [15:0] addr;
    logic [31:0] wdata, rdata;

    int tests = 0, fails = 0, cyc = 0;
    int fault_word = -1, fault_read = 0, lat = 0;
    int wr_n, rd_n, wr_err, rd_err, ovl_err, done_n;
    int rcount [64];
    logic [31:0] mem [64];
    logic        pend = 1'b0;
    int          pcnt = 0;
    logic [31:0] pdata = '0;

    always #5 clk = ~clk;

    mem_readback_tester u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .err_flags_i(err),
        .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
        .mem_rdata_i(rdata), .mem_rvalid_i(rvalid),
        .busy_o(busy), .done_o(done), .pass_o(pass)
    );

    function automatic logic [31:0] exp_word(int i);
        int g = i / 16, p = i % 16;
        bit second = (p == 2 || p == 3 || p == 6 || p == 7 ||
                      p == 8 || p == 9 || p == 12 || p == 13);
        case (g)
            0: return second ? 32'hFFFFFFFF : 32'h00000000;
            1: return second ? 32'h55555555 : 32'hAAAAAAAA;
            2: return second ? 32'h5A5A5A5A : 32'hA5A5A5A5;
            default: return second ? 32'h55AA55AA : 32'hAA55AA55;
        endcase
    endfunction

    // memory model with variable latency and fault injection, plus port monitor
    always @(posedge clk) begin
        cyc <= cyc + 1;
        rvalid <= 1'b0;
        if (pend) begin
            if (pcnt == 0) begin
                rvalid <= 1'b1;
                rdata  <= pdata;
                pend   <= 1'b0;
            end else begin
                pcnt <= pcnt - 1;
            end
        end
        if (start && !busy) begin
            wr_n = 0; rd_n = 0; wr_err = 0; rd_err = 0; ovl_err = 0; done_n = 0;
            for (int k = 0; k < 64; k++) rcount[k] = 0;
        end
        if (done) done_n = done_n + 1;
        if (req && we) begin
            if (addr != BASE + 16'(wr_n) || wdata != exp_word(wr_n)) wr_err = wr_err + 1;
            mem[6'(addr - BASE)] <= wdata;
            wr_n = wr_n + 1;
        end
        if (req && !we) begin
            int w;
            w = int'(6'(addr - BASE));
            if (pend || addr != BASE + 16'(rd_n / 10)) rd_err = rd_err + 1;
            if (pend) ovl_err = ovl_err + 1;
            pend  <= 1'b1;
            pcnt  <= lat;
            pdata <= mem[w] ^ ((w == fault_word && rcount[w] == fault_read) ? 32'h1 : 32'h0);
            rcount[w] = rcount[w] + 1;
            rd_n = rd_n + 1;
        end
    end

    task automatic check(bit ok, string req_tag, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, expv);
        end
    endtask

    task automatic run(int fw, int fr, int errv, int lt, int exp_pass, bit clear_err_early);
        int t = 0;
        int exp_reads = (fw < 0) ? 640 : fw * 10 + fr + 1;
        @(negedge clk);
        fault_word = fw; fault_read = fr; lat = lt; err = 6'(errv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && pass == 1'b0, "R8 busy/pass after start", {30'd0, busy, pass}, 2);
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (clear_err_early && t == 200) err = '0;
        end
        check(done == 1'b1, "R7 done seen", done, 1);
        check(pass == exp_pass[0], "R5 R6 pass result", pass, exp_pass);
        check(busy == 1'b0, "R8 busy low at done", busy, 0);
        check(rd_n == exp_reads, "R4 R5 read count", rd_n, exp_reads);
        check(wr_n == 64 && wr_err == 0, "R2 R3 writes", wr_err, 0);
        check(rd_err == 0 && ovl_err == 0, "R4 read order/outstanding", rd_err + ovl_err, 0);
        repeat (5) begin
            @(negedge clk);
            if (req) rd_err++;
        end
        check(rd_err == 0 && done_n == 1, "R5 R7 quiet after done", done_n, 1);
        check(pass == exp_pass[0], "R7 pass held", pass, exp_pass);
        err = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req == 1'b0 && busy == 1'b0 && done == 1'b0 && pass == 1'b0,
              "R1 reset outputs", {28'd0, req, busy, done, pass}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(req == 1'b0 && busy == 1'b0 && pass == 1'b0, "R1 idle after reset", {29'd0, req, busy, pass}, 0);

        for (int v = 0; v < NV; v++)
            run(V_FW[v], V_FR[v], V_ERR[v], V_LAT[v], V_PASS[v], 1'b0);

        // R6: flags raised only early in the run do not affect the result
        run(-1, 0, 6'h3F, 0, 1, 1'b1);

        // R8: start pulses during a run are ignored
        @(negedge clk);
        fault_word = -1; lat = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (700) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(wr_n == 64 && rd_n == 640 && done_n == 1 && pass == 1'b1,
              "R8 start during busy ignored", wr_n, 64);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule